// File: doc/BRIEF.md
# Clock Policy Mask Controller

This block keeps, for a clock control unit, one enable mask per power policy. Each bit position stands for one downstream clock and means the same clock in every mask. A 2-bit policy select picks which mask currently drives the per-clock enable outputs. Software reaches the block through a plain register bus: an address, write data, a write strobe and a combinational read-data return.

Register writes are guarded in two ways. First, a fixed key value must be written to the access register at word address 0 before any other register write is accepted. Second, masks may be rewritten only while the policy engine is halted. Halting is a single control bit. Restarting takes a go command that carries one of two mode bits. While the engine is halted, the enable outputs freeze at their last values. Once it restarts, they follow the selected mask again.

Word map: 0 = access (bit 0 reads the unlock state), 1 = engine control, 2 to 2+NUM_POL-1 = policy masks, with mask p at address 2+p. Control bits: bit 0 halt, bit 1 go, bit 2 mode A, bit 3 mode B, bit 4 sticky error.

Top module: `clk_policy_ctrl`

## Requirements
- R1: After reset the block is locked (address 0 reads 0), the engine runs, control reads 0, every mask reads all ones and clk_en is all ones.
- R2: Writing KEY to address 0 unlocks the block (address 0 bit 0 reads 1). Writing any other value to address 0 locks it again. Nothing else unlocks it.
- R3: While the block is locked, writes to any address other than 0 are dropped: control and masks keep their values.
- R4: An unlocked write to control with bit 0 set halts the engine, and control bit 0 then reads 1.
- R5: An unlocked write to address 2+p while halted stores the low NUM_CLK data bits as mask p, and that value reads back at the same address.
- R6: An unlocked mask write while the engine runs is discarded and sets the error flag (control bit 4). The flag stays set until an unlocked control write with bit 4 set clears it.
- R7: An unlocked control write with bit 1 (go) set together with bit 2 or bit 3 restarts the engine (control bit 0 reads 0). Control bit 1 always reads 0.
- R8: A go write with neither bit 2 nor bit 3 set leaves the engine state unchanged.
- R9: While the engine runs, clk_en takes the value of the mask chosen by pol_sel one clock later. While it is halted, clk_en holds its value.
- R10: Addresses above the last mask read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| pol_sel | input | POL_W | Active policy select |
| clk_en | output | NUM_CLK | Per-clock enables of the active policy |

## Verification
The bench uses the defaults: 16 clocks, four policies, a 4-bit address and a 32-bit data word. With these values every mask address and several unused addresses are in range, and each of the four policies can hold a distinct pattern that the select input can reach. The non-key value written to address 0 differs from the key in many bits. With the default NUM_CLK, a stored mask differs visibly from the all-ones reset value.

// File: rtl/clk_policy_ctrl.sv
module clk_policy_ctrl #(
  parameter int NUM_CLK = 16,
  parameter int POL_W = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hC10C_4B1D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [POL_W-1:0]   pol_sel,
  output logic [NUM_CLK-1:0] clk_en
);
  localparam int NUM_POL = 1 << POL_W;
  localparam int MASK_BASE = 2;
  localparam logic [ADDR_W-1:0] A_ACC = '0;
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(1);
  localparam int B_HALT = 0;
  localparam int B_GO = 1;
  localparam int B_MODE_A = 2;
  localparam int B_MODE_B = 3;
  localparam int B_ERR = 4;

  logic                             unlocked_q;
  logic                             halted_q;
  logic                             err_q;
  logic [NUM_POL-1:0][NUM_CLK-1:0]  mask_q;

  logic [ADDR_W-1:0] moff;
  logic [POL_W-1:0]  midx;
  logic              is_mask, wr_ok, go_ok;

  assign moff    = addr - ADDR_W'(MASK_BASE);
  assign midx    = moff[POL_W-1:0];
  assign is_mask = (addr >= ADDR_W'(MASK_BASE)) && (moff < ADDR_W'(NUM_POL));
  assign wr_ok   = we && unlocked_q;
  assign go_ok   = wdata[B_GO] && (wdata[B_MODE_A] || wdata[B_MODE_B]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      halted_q   <= 1'b0;
      err_q      <= 1'b0;
      mask_q     <= '1;
      clk_en     <= '1;
    end else begin
      if (we && addr == A_ACC)
        unlocked_q <= (wdata == KEY);
      if (wr_ok && addr == A_CTL) begin
        if (go_ok)
          halted_q <= 1'b0;
        else if (wdata[B_HALT])
          halted_q <= 1'b1;
        if (wdata[B_ERR])
          err_q <= 1'b0;
      end
      if (wr_ok && is_mask) begin
        if (halted_q)
          mask_q[midx] <= wdata[NUM_CLK-1:0];
        else
          err_q <= 1'b1;
      end
      if (!halted_q)
        clk_en <= mask_q[pol_sel];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_ACC)
      rdata[0] = unlocked_q;
    else if (addr == A_CTL) begin
      rdata[B_HALT] = halted_q;
      rdata[B_ERR]  = err_q;
    end else if (is_mask)
      rdata[NUM_CLK-1:0] = mask_q[midx];
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata;
endmodule

// File: rtl/clk_policy_ctrl_chk.sv
module clk_policy_ctrl_chk #(
  parameter int NUM_CLK = 16,
  parameter int POL_W = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hC10C_4B1D
) (
  input logic clk,
  input logic rst_n,
  input logic we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [POL_W-1:0] pol_sel,
  input logic [NUM_CLK-1:0] clk_en,
  input logic unlocked_q,
  input logic halted_q,
  input logic err_q,
  input logic [(1<<POL_W)-1:0][NUM_CLK-1:0] mask_q
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(1);

  AST_UNLOCK_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(we && addr == '0 && wdata == KEY)); // R2
  AST_LOCK_HOLDS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> $stable(mask_q)); // R3
  AST_RUN_HOLDS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_q |=> $stable(mask_q)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(we && unlocked_q && addr == A_CTL && wdata[4]) |=> err_q); // R6
  AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_CTL |-> !rdata[1]); // R7
  AST_BARE_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q && we && unlocked_q && addr == A_CTL && wdata[1] && wdata[3:2] == 2'b00
    |=> halted_q); // R8
  AST_HALT_FREEZES_EN: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> $stable(clk_en)); // R9
  AST_RUN_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_q |=> clk_en == $past(mask_q[pol_sel])); // R9
endmodule

bind clk_policy_ctrl clk_policy_ctrl_chk #(
  .NUM_CLK(NUM_CLK), .POL_W(POL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
  .pol_sel(pol_sel), .clk_en(clk_en), .unlocked_q(unlocked_q), .halted_q(halted_q),
  .err_q(err_q), .mask_q(mask_q)
);

// File: tb/clk_policy_ctrl_tb.sv
module clk_policy_ctrl_tb;
  localparam logic [31:0] KEY = 32'hC10C_4B1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] pol_sel = '0;
  logic [15:0] clk_en;

  clk_policy_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pol_sel(pol_sel), .clk_en(clk_en)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit          is_en;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_en = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_en(input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_en = 1'b1; it.exp = {16'h0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [31:0] act;
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        act = it.is_en ? {16'h0, clk_en} : rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    exp_rd(4'd0, 32'h0, "R1 locked");
    exp_rd(4'd1, 32'h0, "R1 ctrl");
    exp_rd(4'd4, 32'h0000_FFFF, "R1 mask2");
    exp_en(16'hFFFF, "R1 clk_en");

    wr(4'd1, 32'h1);
    exp_rd(4'd1, 32'h0, "R3 ctrl locked");
    wr(4'd3, 32'h0000_1111);
    exp_rd(4'd3, 32'h0000_FFFF, "R3 mask locked");

    wr(4'd0, KEY);
    exp_rd(4'd0, 32'h1, "R2 unlock");

    wr(4'd4, 32'h0000_1234);
    exp_rd(4'd4, 32'h0000_FFFF, "R6 mask discarded");
    exp_rd(4'd1, 32'h10, "R6 err set");

    wr(4'd1, 32'h1);
    exp_rd(4'd1, 32'h11, "R4 halted");
    wr(4'd1, 32'h10);
    exp_rd(4'd1, 32'h01, "R6 err cleared");

    wr(4'd2, 32'h0000_00F0);
    wr(4'd3, 32'h0000_0F0F);
    wr(4'd4, 32'hFFFF_A5A5);
    wr(4'd5, 32'h0000_8001);
    exp_rd(4'd2, 32'h0000_00F0, "R5 mask0");
    exp_rd(4'd3, 32'h0000_0F0F, "R5 mask1");
    exp_rd(4'd4, 32'h0000_A5A5, "R5 mask2");
    exp_rd(4'd5, 32'h0000_8001, "R5 mask3");

    @(negedge clk) pol_sel = 2'd2;
    repeat (2) @(negedge clk);
    exp_en(16'hFFFF, "R9 hold halted");

    wr(4'd1, 32'h2);
    exp_rd(4'd1, 32'h01, "R8 bare go");
    exp_en(16'hFFFF, "R8 en held");

    wr(4'd1, 32'h6);
    exp_rd(4'd1, 32'h00, "R7 go mode A");
    exp_en(16'hA5A5, "R9 policy2");
    @(negedge clk) pol_sel = 2'd3;
    @(negedge clk);
    exp_en(16'h8001, "R9 policy3");
    @(negedge clk) pol_sel = 2'd0;
    @(negedge clk);
    exp_en(16'h00F0, "R9 policy0");

    wr(4'd1, 32'h1);
    exp_rd(4'd1, 32'h01, "R4 halt again");
    @(negedge clk) pol_sel = 2'd1;
    repeat (2) @(negedge clk);
    exp_en(16'h00F0, "R9 hold policy1");
    wr(4'd1, 32'hA);
    exp_rd(4'd1, 32'h00, "R7 go mode B");
    @(negedge clk);
    exp_en(16'h0F0F, "R9 policy1");

    wr(4'd7, 32'hFFFF_FFFF);
    exp_rd(4'd7, 32'h0, "R10 unused read");
    exp_rd(4'd2, 32'h0000_00F0, "R10 mask0 intact");
    exp_rd(4'd1, 32'h00, "R10 ctrl intact");

    wr(4'd0, 32'h0000_DEAD);
    exp_rd(4'd0, 32'h0, "R2 relock");
    wr(4'd1, 32'h1);
    exp_rd(4'd1, 32'h0, "R3 ctrl dropped");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule